// File: doc/BRIEF.md
# Dual-Carrier BPSK Transmit Modulator

This block turns a serial stream of packet bits into a binary phase-shift keyed carrier. Each clock it produces one signed sample for an external DAC. Bits arrive over a ready/valid handshake. The block holds each bit for a whole bit period, and the last bit of a packet is marked by a flag that travels with it. A numerically controlled oscillator with a 24-bit phase accumulator makes the carrier. The top 8 bits of the accumulator address a quarter-wave sine table, and the table yields 10-bit two's-complement samples.

The block serves two bands, and each band has its own system clock and its own raw bit rate. The general-signalling band (`band_sel` = 1) runs from a 10 MHz clock at 5.4 kbps, with a 132 kHz primary carrier and a 115 kHz secondary carrier. The utility band (`band_sel` = 0) runs from a 6.5536 MHz clock at 3.6 kbps, with carriers of 86 kHz and 75 kHz. Phase increments and bit dividers are worked out at elaboration for the matching clock.

A receive-side report that the primary carrier is blocked is remembered until the next packet starts. That packet is then sent on the secondary carrier. Band and carrier never change inside a packet. Two status outputs show that a packet is in progress and that the secondary carrier is in use.

Top module: `bpsk_tx_mod`

## Requirements
- R1: After reset `sample` is 0, `tx_active` and `band_in_use` are low, and `bit_ready` is high.
- R2: The phase increment is round(f·2^24/fclk), using the carrier and clock of the latched band. The 24-bit accumulator is set to 0 when a packet starts and advances by one increment in every transmitting cycle.
- R3: A transmitted sample is 511·sin(2π·P/256) within ±2 LSB, where P is bits 23..16 of the accumulator. Its magnitude never exceeds 511.
- R4: A data bit of 1 sends the carrier at 0°. A data bit of 0 sends the same sample negated (180°).
- R5: A bit period lasts D = round(fclk/bitrate) cycles: 1852 in the general band and 1820 in the utility band. While a packet is being sent, `bit_ready` is high only in the last cycle of each bit period, and never in the middle of a bit.
- R6: `tx_active` rises one cycle after the edge that accepts the first bit. It stays high for exactly n·D cycles for an n-bit packet, and it lines up with the carrier samples.
- R7: The secondary carrier is chosen when `carrier_blocked` is high at the edge that starts the packet, or was high at any edge since the previous packet started. Starting a packet clears this memory.
- R8: `band_in_use` is high exactly while `tx_active` is high and the packet uses the secondary carrier.
- R9: Band and carrier are latched when a packet starts. Changes on `band_sel` or `carrier_blocked` during the packet do not affect its samples or its status.
- R10: A packet ends after the bit flagged with `pkt_last`. It also ends at a bit boundary where no bit is offered (underrun).
- R11: Outside a packet `sample` is 0, and the first sample of every packet is 0 because its phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (10 MHz or 6.5536 MHz, matching the band) |
| rst_n | input | 1 | Active-low synchronous reset |
| band_sel | input | 1 | 1 = general-signalling band, 0 = utility band |
| carrier_blocked | input | 1 | Receive side reports the primary carrier blocked |
| bit_data | input | 1 | Data bit offered |
| pkt_last | input | 1 | Offered bit is the last of its packet |
| bit_valid | input | 1 | A bit is offered |
| bit_ready | output | 1 | The offered bit is taken at this edge |
| sample | output | 10 | Signed carrier sample for the DAC |
| tx_active | output | 1 | Packet being transmitted |
| band_in_use | output | 1 | Transmitting on the secondary carrier |

## Verification
The edge that accepts the first bit clears the phase. The sample for transmitting cycle t, with phase t·inc, appears one registered cycle later. The bench therefore compares the output after edge t+1 with its own accumulator model for cycle t. It checks `tx_active` and `band_in_use` on the same cycles as the samples. Ready is checked in the last cycle of each bit period, where it must be high, and at mid-bit, where it must be low. Every comparison is sampled at the falling edge, so the registered outputs have settled.

// File: rtl/bpsk_tx_pkg.sv
package bpsk_tx_pkg;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    // Rounded phase step: f * 2^w / clk
    function automatic longint calc_inc(input longint f_hz, input longint clk_hz, input int w);
        return ((f_hz << w) + (clk_hz / 2)) / clk_hz;
    endfunction

    // Rounded clocks per bit
    function automatic longint calc_div(input longint clk_hz, input longint rate);
        return (clk_hz + rate / 2) / rate;
    endfunction

    // Integer rational sine approximation of amp*sin(pi*k/half_n), 0 <= k <= half_n/2
    function automatic longint qmag(input longint k, input longint half_n, input longint amp);
        longint prod;
        longint num;
        longint den;
        prod = k * (half_n - k);
        num  = amp * 16 * prod;
        den  = 5 * half_n * half_n - 4 * prod;
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/bpsk_carrier_sel.sv
module bpsk_carrier_sel #(
    parameter int PHASE_W     = 24,
    parameter int CNT_W       = 11,
    parameter int GEN_CLK_HZ  = 10_000_000,
    parameter int UTIL_CLK_HZ = 6_553_600,
    parameter int GEN_PRI_HZ  = 132_000,
    parameter int GEN_SEC_HZ  = 115_000,
    parameter int UTIL_PRI_HZ = 86_000,
    parameter int UTIL_SEC_HZ = 75_000,
    parameter int GEN_BAUD    = 5_400,
    parameter int UTIL_BAUD   = 3_600
) (
    input  logic               band_gen,
    input  logic               use_sec,
    output logic [PHASE_W-1:0] inc,
    output logic [CNT_W-1:0]   div_m1
);
    import bpsk_tx_pkg::*;

    localparam logic [PHASE_W-1:0] INC_GP = PHASE_W'(calc_inc(GEN_PRI_HZ,  GEN_CLK_HZ,  PHASE_W));
    localparam logic [PHASE_W-1:0] INC_GS = PHASE_W'(calc_inc(GEN_SEC_HZ,  GEN_CLK_HZ,  PHASE_W));
    localparam logic [PHASE_W-1:0] INC_UP = PHASE_W'(calc_inc(UTIL_PRI_HZ, UTIL_CLK_HZ, PHASE_W));
    localparam logic [PHASE_W-1:0] INC_US = PHASE_W'(calc_inc(UTIL_SEC_HZ, UTIL_CLK_HZ, PHASE_W));
    localparam logic [CNT_W-1:0]   DM1_G  = CNT_W'(calc_div(GEN_CLK_HZ,  GEN_BAUD)  - 1);
    localparam logic [CNT_W-1:0]   DM1_U  = CNT_W'(calc_div(UTIL_CLK_HZ, UTIL_BAUD) - 1);

    always_comb begin
        unique case ({band_gen, use_sec})
            2'b11:   inc = INC_GS;
            2'b10:   inc = INC_GP;
            2'b01:   inc = INC_US;
            default: inc = INC_UP;
        endcase
        div_m1 = band_gen ? DM1_G : DM1_U;
    end

endmodule

// File: rtl/bpsk_sine_lut.sv
module bpsk_sine_lut #(
    parameter int LUT_AW   = 8,
    parameter int SAMPLE_W = 10
) (
    input  logic                       en,
    input  logic [LUT_AW-1:0]          idx,
    input  logic                       bit_val,
    output logic signed [SAMPLE_W-1:0] sample
);
    import bpsk_tx_pkg::*;

    localparam int QN    = 1 << (LUT_AW - 2);
    localparam int HALF  = QN * 2;
    localparam int AMP   = (1 << (SAMPLE_W - 1)) - 1;
    localparam int MAG_W = SAMPLE_W - 1;

    logic [MAG_W-1:0] qtab [0:QN];

    generate
        for (genvar k = 0; k <= QN; k++) begin : g_qtab
            assign qtab[k] = MAG_W'(qmag(k, HALF, AMP));
        end
    endgenerate

    logic [1:0]                 quad;
    logic [LUT_AW-3:0]          qpos;
    logic [LUT_AW-2:0]          addr;
    logic [MAG_W-1:0]           mag;
    logic signed [SAMPLE_W-1:0] mag_s;
    logic                       negate;

    always_comb begin
        quad   = idx[LUT_AW-1:LUT_AW-2];
        qpos   = idx[LUT_AW-3:0];
        addr   = quad[0] ? ((LUT_AW-1)'(QN) - {1'b0, qpos}) : {1'b0, qpos};
        mag    = qtab[addr];
        mag_s  = $signed({1'b0, mag});
        negate = quad[1] ^ ~bit_val;
        if (!en)
            sample = '0;
        else if (negate)
            sample = -mag_s;
        else
            sample = mag_s;
    end

endmodule

// File: rtl/bpsk_bit_timer.sv
module bpsk_bit_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             at_end
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (run && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign at_end = (cnt_q == '0);

endmodule

// File: rtl/bpsk_tx_mod.sv
module bpsk_tx_mod #(
    parameter int PHASE_W     = 24,
    parameter int LUT_AW      = 8,
    parameter int SAMPLE_W    = 10,
    parameter int GEN_CLK_HZ  = 10_000_000,
    parameter int UTIL_CLK_HZ = 6_553_600,
    parameter int GEN_PRI_HZ  = 132_000,
    parameter int GEN_SEC_HZ  = 115_000,
    parameter int UTIL_PRI_HZ = 86_000,
    parameter int UTIL_SEC_HZ = 75_000,
    parameter int GEN_BAUD    = 5_400,
    parameter int UTIL_BAUD   = 3_600
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       band_sel,
    input  logic                       carrier_blocked,
    input  logic                       bit_data,
    input  logic                       pkt_last,
    input  logic                       bit_valid,
    output logic                       bit_ready,
    output logic signed [SAMPLE_W-1:0] sample,
    output logic                       tx_active,
    output logic                       band_in_use
);
    import bpsk_tx_pkg::*;

    localparam int DIV_G   = int'(calc_div(GEN_CLK_HZ,  GEN_BAUD));
    localparam int DIV_U   = int'(calc_div(UTIL_CLK_HZ, UTIL_BAUD));
    localparam int DIV_MAX = (DIV_G > DIV_U) ? DIV_G : DIV_U;
    localparam int CNT_W   = $clog2(DIV_MAX + 1);

    typedef struct packed {
        tx_state_e           state;
        logic [PHASE_W-1:0]  acc;
        logic                data;
        logic                last;
        logic                band;
        logic                sec;
        logic                pend;
        logic [SAMPLE_W-1:0] smp;
        logic                active;
        logic                biu;
    } mod_state_t;

    mod_state_t s_d, s_q;

    logic                       busy;
    logic                       tmr_zero;
    logic                       tmr_load;
    logic                       sel_band;
    logic                       sel_sec;
    logic [PHASE_W-1:0]         inc;
    logic [CNT_W-1:0]           div_m1;
    logic signed [SAMPLE_W-1:0] lut_sample;

    assign busy     = (s_q.state == TX_SEND);
    assign sel_band = busy ? s_q.band : band_sel;
    assign sel_sec  = busy ? s_q.sec  : (carrier_blocked | s_q.pend);

    bpsk_carrier_sel #(
        .PHASE_W    (PHASE_W),
        .CNT_W      (CNT_W),
        .GEN_CLK_HZ (GEN_CLK_HZ),
        .UTIL_CLK_HZ(UTIL_CLK_HZ),
        .GEN_PRI_HZ (GEN_PRI_HZ),
        .GEN_SEC_HZ (GEN_SEC_HZ),
        .UTIL_PRI_HZ(UTIL_PRI_HZ),
        .UTIL_SEC_HZ(UTIL_SEC_HZ),
        .GEN_BAUD   (GEN_BAUD),
        .UTIL_BAUD  (UTIL_BAUD)
    ) carrier_i (
        .band_gen(sel_band),
        .use_sec (sel_sec),
        .inc     (inc),
        .div_m1  (div_m1)
    );

    bpsk_sine_lut #(
        .LUT_AW  (LUT_AW),
        .SAMPLE_W(SAMPLE_W)
    ) lut_i (
        .en     (busy),
        .idx    (s_q.acc[PHASE_W-1 -: LUT_AW]),
        .bit_val(s_q.data),
        .sample (lut_sample)
    );

    bpsk_bit_timer #(
        .CNT_W(CNT_W)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(div_m1),
        .run     (busy),
        .at_end  (tmr_zero)
    );

    assign bit_ready = !busy || (tmr_zero && !s_q.last);

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        s_d.pend   = s_q.pend | carrier_blocked;
        s_d.active = busy;
        s_d.biu    = busy & s_q.sec;
        s_d.smp    = lut_sample;
        unique case (s_q.state)
            TX_IDLE: begin
                if (bit_valid) begin
                    s_d.state = TX_SEND;
                    s_d.acc   = '0;
                    s_d.data  = bit_data;
                    s_d.last  = pkt_last;
                    s_d.band  = band_sel;
                    s_d.sec   = carrier_blocked | s_q.pend;
                    s_d.pend  = 1'b0;
                    tmr_load  = 1'b1;
                end
            end
            TX_SEND: begin
                s_d.acc = s_q.acc + inc;
                if (tmr_zero) begin
                    if (!s_q.last && bit_valid) begin
                        s_d.data = bit_data;
                        s_d.last = pkt_last;
                        tmr_load = 1'b1;
                    end else begin
                        s_d.state = TX_IDLE;
                    end
                end
            end
            default: s_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign sample      = s_q.smp;
    assign tx_active   = s_q.active;
    assign band_in_use = s_q.biu;

endmodule

// File: rtl/bpsk_tx_mod_chk.sv
module bpsk_tx_mod_chk #(
    parameter int SAMPLE_W = 10
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bit_valid,
    input logic                       bit_ready,
    input logic signed [SAMPLE_W-1:0] sample,
    input logic                       tx_active,
    input logic                       band_in_use,
    input logic                       busy,
    input logic                       tmr_zero
);
    localparam logic signed [SAMPLE_W-1:0] SMIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

    // R11: phase starts at zero, so the first sample of a packet is zero
    assert_first_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> (sample == '0));

    // R11 / R8: quiet outputs between packets
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> (sample == '0) && !band_in_use);

    // R8: secondary indication only during a packet
    assert_biu_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        band_in_use |-> tx_active);

    // R9: carrier choice stays fixed within a packet
    assert_carrier_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && $past(tx_active)) |-> $stable(band_in_use));

    // R3: magnitude bound
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample != SMIN);

    // R5: a bit taken mid-packet restarts a full bit period
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bit_valid && bit_ready) |=> !tmr_zero);

endmodule

bind bpsk_tx_mod bpsk_tx_mod_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .bit_ready  (bit_ready),
    .sample     (sample),
    .tx_active  (tx_active),
    .band_in_use(band_in_use),
    .busy       (busy),
    .tmr_zero   (tmr_zero)
);

// File: tb/bpsk_tx_mod_tb_top.sv
module bpsk_tx_mod_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              band_sel = 1'b0;
    logic              carrier_blocked = 1'b0;
    logic              bit_data = 1'b0;
    logic              pkt_last = 1'b0;
    logic              bit_valid = 1'b0;
    logic              bit_ready;
    logic signed [9:0] sample;
    logic              tx_active;
    logic              band_in_use;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  m_pend   = 1'b0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    bpsk_tx_mod dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .band_sel       (band_sel),
        .carrier_blocked(carrier_blocked),
        .bit_data       (bit_data),
        .pkt_last       (pkt_last),
        .bit_valid      (bit_valid),
        .bit_ready      (bit_ready),
        .sample         (sample),
        .tx_active      (tx_active),
        .band_in_use    (band_in_use)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int unsigned exp_inc(input bit gen, input bit sec);
        real f;
        real c;
        c = gen ? 10.0e6 : 6.5536e6;
        if (gen) f = sec ? 115.0e3 : 132.0e3;
        else     f = sec ? 75.0e3  : 86.0e3;
        return $rtoi(f * 16777216.0 / c + 0.5);
    endfunction

    function automatic int exp_div(input bit gen);
        return gen ? $rtoi(10.0e6 / 5400.0 + 0.5) : $rtoi(6.5536e6 / 3600.0 + 0.5);
    endfunction

    function automatic real exp_wave(input logic [23:0] acc, input bit b);
        real v;
        v = 511.0 * $sin(2.0 * 3.14159265358979 * $itor(acc[23:16]) / 256.0);
        return b ? v : -v;
    endfunction

    // Sends an n-bit packet and checks every cycle of it (R2..R11)
    task automatic tx_packet(input bit [7:0] bits, input int n, input bit gen,
                             input bit blk_start, input bit underrun, input bit disturb);
        bit          sec;
        int          dv;
        int unsigned inc;
        logic [23:0] acc_m;
        real         ev;
        int          total;
        @(negedge clk);
        chk(bit_ready == 1'b1, "R5", "ready while idle", int'(bit_ready), 1);
        band_sel        = gen;
        carrier_blocked = blk_start;
        sec             = m_pend | blk_start;
        m_pend          = 1'b0;
        bit_valid       = 1'b1;
        bit_data        = bits[0];
        pkt_last        = (n == 1) && !underrun;
        dv    = exp_div(gen);
        inc   = exp_inc(gen, sec);
        acc_m = '0;
        total = n * dv;
        @(posedge clk);
        @(negedge clk);
        carrier_blocked = 1'b0;
        if (n == 1) bit_valid = 1'b0;
        if (disturb) band_sel = ~gen;
        for (int t = 0; t < total; t++) begin
            int nxt;
            @(posedge clk);
            @(negedge clk);
            ev = exp_wave(acc_m, bits[t / dv]);
            if (t == 0)
                chk(sample == 10'sd0, "R11", "first sample", int'(sample), 0);
            chk(($itor(sample) - ev <= 2.0) && (ev - $itor(sample) <= 2.0),
                bits[t / dv] ? "R3" : "R4", "carrier sample", int'(sample), $rtoi(ev));
            chk(tx_active == 1'b1, "R6", "tx_active in packet", int'(tx_active), 1);
            chk(band_in_use == sec, sec ? "R7" : "R8", "band_in_use", int'(band_in_use), int'(sec));
            acc_m = acc_m + inc[23:0];
            nxt = t + 1;
            if (nxt < total) begin
                if ((nxt % dv) == dv - 1) begin
                    if ((nxt / dv) + 1 < n) begin
                        chk(bit_ready == 1'b1, "R5", "ready at boundary", int'(bit_ready), 1);
                        bit_data = bits[(nxt / dv) + 1];
                        pkt_last = ((nxt / dv) + 1 == n - 1) && !underrun;
                    end
                end else if ((nxt % dv) == dv / 2) begin
                    chk(bit_ready == 1'b0, "R5", "ready mid-bit", int'(bit_ready), 0);
                end
                if (n > 1 && nxt == (n - 1) * dv) bit_valid = 1'b0;
                if (disturb && nxt == dv / 3) begin
                    carrier_blocked = 1'b1;
                    m_pend = 1'b1;
                end
                if (disturb && nxt == dv / 3 + 1) carrier_blocked = 1'b0;
                if (disturb && (nxt % dv) == dv / 4) band_sel = $urandom_range(0, 1);
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(tx_active == 1'b0, underrun ? "R10" : "R6", "tx_active after packet", int'(tx_active), 0);
        chk(sample == 10'sd0, "R11", "idle sample", int'(sample), 0);
        chk(band_in_use == 1'b0, "R8", "band_in_use idle", int'(band_in_use), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(sample == 10'sd0, "R1", "reset sample", int'(sample), 0);
        chk(tx_active == 1'b0, "R1", "reset tx_active", int'(tx_active), 0);
        chk(band_in_use == 1'b0, "R1", "reset band_in_use", int'(band_in_use), 0);
        chk(bit_ready == 1'b1, "R1", "reset ready", int'(bit_ready), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R2 R4: general band, primary, mixed bits
        tx_packet(8'b0000_0101, 3, 1'b1, 1'b0, 1'b0, 1'b0);
        // R2 R5: utility band, primary
        tx_packet(8'b0000_0010, 2, 1'b0, 1'b0, 1'b0, 1'b0);
        // R7: blocked at start -> secondary
        tx_packet(8'b0000_0001, 1, 1'b1, 1'b1, 1'b0, 1'b0);
        // R7: blocked pulse while idle is remembered
        @(negedge clk); carrier_blocked = 1'b1; m_pend = 1'b1;
        @(negedge clk); carrier_blocked = 1'b0;
        repeat (5) @(negedge clk);
        tx_packet(8'b0000_0000, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R7: memory cleared -> back to primary
        tx_packet(8'b0000_0001, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R10: underrun ends the packet
        tx_packet(8'b0000_0011, 2, 1'b1, 1'b0, 1'b1, 1'b0);
        // R9: band changes and blocked pulse inside a packet
        tx_packet(8'b0000_0110, 3, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 6; i++) begin
            tx_packet(8'($urandom()), $urandom_range(1, 2), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            repeat ($urandom_range(1, 6)) @(negedge clk);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule